// File: doc/BRIEF.md
# Full-Track Read Sequencer

This block steers a command that reads every data field on one disk track. Once a legal command is accepted it waits for the index pulse and then takes sectors in the order they pass the head, without choosing them by logical sector number. Each ID field that the front end decodes is compared with the ID held from the command. Each completed data field adds one to a sector count, and the command ends once that count reaches the end-of-track value.

CRC errors in ID or data fields do not stop the read. They are kept as sticky flags and reported when the command ends. If no ID mark appears before a second index pulse, the command ends with an abnormal completion code and a missing-mark flag. A command byte that asks for multi-track or skip operation is refused at once. The bit decoding and the byte transfer sit outside this block: it sees only strobes and decoded fields.

Top module: `trk_read_seq`

## Requirements
- R1: After reset `busy` and `done` are 0, `st_code` is 00 and all four status flags are 0.
- R2: A legal command (bits 7 and 5 of `cmd_byte` both 0) sets `busy`. ID and data strobes that arrive before the first index pulse are ignored.
- R3: A command whose `cmd_byte` has bit 7 (multi-track) or bit 5 (skip) set is refused. `done` rises in the cycle after the start edge, `st_code` is 01 and no flag is set.
- R4: After the index pulse, sectors are taken in arrival order whatever their ID contents. Each ID strobe followed by a data strobe counts as one sector.
- R5: An ID strobe whose `id_value` differs from the `cmd_id` latched at start sets `st_nomatch`, which stays set until the command ends.
- R6: `id_crc_err` given with an ID strobe sets `st_crc_id`, and `data_crc_err` given with a data strobe sets `st_crc_data`. Neither stops the read.
- R7: When the sector count reaches `cmd_eot` (0 is treated as 1), the command ends with `st_code` 00.
- R8: While the block waits for an ID, a second index pulse since the starting index pulse or since the last ID strobe ends the command. It sets `st_missing` and `st_code` 01.
- R9: `done` is high for exactly one cycle at the end of each command. `busy` is then 0, and the status outputs hold until the next command is accepted.
- R10: Accepting a new command clears all four status flags.
- R11: `cmd_start` while a command runs is ignored. A data strobe while the block waits for an ID is ignored, as is an index pulse during a data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command issue strobe |
| cmd_byte | input | CMDW | First command byte (multi-track bit 7, skip bit 5) |
| cmd_id | input | IDW | ID expected on the track, latched at start |
| cmd_eot | input | CNTW | Number of sectors to read, latched at start |
| index_pulse | input | 1 | One-cycle index hole strobe |
| id_found | input | 1 | ID address mark decoded strobe |
| id_value | input | IDW | Decoded ID fields, valid with `id_found` |
| id_crc_err | input | 1 | ID CRC error, valid with `id_found` |
| data_done | input | 1 | Data field finished strobe |
| data_crc_err | input | 1 | Data CRC error, valid with `data_done` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| st_code | output | 2 | Completion code: 00 normal, 01 abnormal |
| st_nomatch | output | 1 | Some ID differed from the command ID |
| st_missing | output | 1 | No ID mark found before the second index pulse |
| st_crc_id | output | 1 | ID CRC error seen |
| st_crc_data | output | 1 | Data CRC error seen |

## Verification
The embedded properties check on every cycle that `done` never lasts two cycles and that a missing-mark abort always carries code 01. They also check that a refused command completes one cycle after its start, that a mismatch flag only rises after an ID strobe, that acceptance clears the flags, and that the index counter and sector count stay in range. Whether strobes in the wrong phase are ignored, whether the end-of-track count and the zero-count case end the read at the right sector, and whether an abort happens after exactly two index pulses can only be shown by the bench scenarios. In those scenarios a behavioural model tracks every output on every clock.

// File: rtl/trk_pkg.sv
package trk_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT_INDEX,
      S_WAIT_ID,
      S_READ_DATA,
      S_DONE
   } trk_state_e;

   localparam logic [1:0] CODE_NORMAL   = 2'b00;
   localparam logic [1:0] CODE_ABNORMAL = 2'b01;
endpackage

// File: rtl/trk_cmd_check.sv
module trk_cmd_check #(
   parameter int CMDW   = 8,
   parameter int MT_BIT = 7,
   parameter int SK_BIT = 5
) (
   input  logic [CMDW-1:0] cmd_byte,
   output logic            illegal
);
   localparam logic [CMDW-1:0] REJECT_MASK =
      (CMDW'(1) << MT_BIT) | (CMDW'(1) << SK_BIT);

   initial begin
      assert (MT_BIT < CMDW && SK_BIT < CMDW && MT_BIT != SK_BIT)
         else $error("trk_cmd_check: option bit positions out of range");
   end

   assign illegal = |(cmd_byte & REJECT_MASK);
endmodule

// File: rtl/trk_miss_counter.sv
module trk_miss_counter #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   initial begin
      assert (LIMIT >= 1) else $error("trk_miss_counter: LIMIT must be at least 1");
   end

   assign hit = inc && !clr && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= inc ? CW'(1) : '0;
      end else if (inc && !hit) begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT));
endmodule

// File: rtl/trk_id_compare.sv
module trk_id_compare #(
   parameter int IDW = 32,
   parameter int LANEW = 8
) (
   input  logic [IDW-1:0] expect_id,
   input  logic [IDW-1:0] seen_id,
   output logic           mismatch
);
   localparam int LANES = IDW / LANEW;

   initial begin
      assert (IDW % LANEW == 0 && LANES >= 1)
         else $error("trk_id_compare: IDW must be a multiple of LANEW");
   end

   logic [LANES-1:0] lane_diff;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_diff[g] =
         expect_id[g*LANEW +: LANEW] != seen_id[g*LANEW +: LANEW];
   end

   assign mismatch = |lane_diff;
endmodule

// File: rtl/trk_read_seq.sv
module trk_read_seq
   import trk_pkg::*;
#(
   parameter int CMDW       = 8,
   parameter int MT_BIT     = 7,
   parameter int SK_BIT     = 5,
   parameter int IDW        = 32,
   parameter int CNTW       = 8,
   parameter int MISS_LIMIT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_start,
   input  logic [CMDW-1:0] cmd_byte,
   input  logic [IDW-1:0]  cmd_id,
   input  logic [CNTW-1:0] cmd_eot,
   input  logic            index_pulse,
   input  logic            id_found,
   input  logic [IDW-1:0]  id_value,
   input  logic            id_crc_err,
   input  logic            data_done,
   input  logic            data_crc_err,
   output logic            busy,
   output logic            done,
   output logic [1:0]      st_code,
   output logic            st_nomatch,
   output logic            st_missing,
   output logic            st_crc_id,
   output logic            st_crc_data
);
   trk_state_e      state;
   logic [IDW-1:0]  id_q;
   logic [CNTW-1:0] eot_q;
   logic [CNTW-1:0] sec_cnt;
   logic [CNTW:0]   sec_next;
   logic            illegal, mismatch, last_sector;
   logic            cnt_clr, cnt_inc, miss_hit, accept;

   initial begin
      assert (CNTW >= 1 && MISS_LIMIT >= 1)
         else $error("trk_read_seq: bad counter parameters");
   end

   trk_cmd_check #(.CMDW(CMDW), .MT_BIT(MT_BIT), .SK_BIT(SK_BIT)) u_cmd (
      .cmd_byte (cmd_byte),
      .illegal  (illegal)
   );

   trk_id_compare #(.IDW(IDW)) u_cmp (
      .expect_id (id_q),
      .seen_id   (id_value),
      .mismatch  (mismatch)
   );

   trk_miss_counter #(.LIMIT(MISS_LIMIT)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .hit   (miss_hit)
   );

   assign accept      = (state == S_IDLE) && cmd_start;
   assign sec_next    = {1'b0, sec_cnt} + 1'b1;
   assign last_sector = sec_next >= {1'b0, eot_q};

   always_comb begin
      cnt_clr = accept
             || ((state == S_WAIT_INDEX) && index_pulse)
             || ((state == S_WAIT_ID) && id_found);
      cnt_inc = ((state == S_WAIT_INDEX) && index_pulse)
             || ((state == S_WAIT_ID) && index_pulse && !id_found);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         id_q        <= '0;
         eot_q       <= '0;
         sec_cnt     <= '0;
         st_code     <= CODE_NORMAL;
         st_nomatch  <= 1'b0;
         st_missing  <= 1'b0;
         st_crc_id   <= 1'b0;
         st_crc_data <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (cmd_start) begin
               st_nomatch  <= 1'b0;
               st_missing  <= 1'b0;
               st_crc_id   <= 1'b0;
               st_crc_data <= 1'b0;
               id_q        <= cmd_id;
               eot_q       <= (cmd_eot == '0) ? CNTW'(1) : cmd_eot;
               sec_cnt     <= '0;
               if (illegal) begin
                  st_code <= CODE_ABNORMAL;
                  state   <= S_DONE;
               end else begin
                  st_code <= CODE_NORMAL;
                  state   <= S_WAIT_INDEX;
               end
            end
            S_WAIT_INDEX: if (index_pulse) state <= S_WAIT_ID;
            S_WAIT_ID: begin
               if (id_found) begin
                  if (mismatch)   st_nomatch <= 1'b1;
                  if (id_crc_err) st_crc_id  <= 1'b1;
                  state <= S_READ_DATA;
               end else if (miss_hit) begin
                  st_missing <= 1'b1;
                  st_code    <= CODE_ABNORMAL;
                  state      <= S_DONE;
               end
            end
            S_READ_DATA: if (data_done) begin
               if (data_crc_err) st_crc_data <= 1'b1;
               sec_cnt <= sec_next[CNTW-1:0];
               state   <= last_sector ? S_DONE : S_WAIT_ID;
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy = (state == S_WAIT_INDEX) || (state == S_WAIT_ID) || (state == S_READ_DATA);
   assign done = (state == S_DONE);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_missing_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_missing |-> (st_code == CODE_ABNORMAL));
   assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && illegal) |=> (done && st_code == CODE_ABNORMAL && !st_missing));
   assert_nomatch_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_nomatch) |-> $past(id_found));
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !(st_nomatch || st_missing || st_crc_id || st_crc_data));
   assert_sector_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sec_cnt < eot_q));
endmodule

// File: tb/trk_read_seq_test.sv
module trk_read_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [7:0]  cmd_byte = '0;
   logic [31:0] cmd_id = '0;
   logic [7:0]  cmd_eot = '0;
   logic        index_pulse = 1'b0;
   logic        id_found = 1'b0;
   logic [31:0] id_value = '0;
   logic        id_crc_err = 1'b0;
   logic        data_done = 1'b0;
   logic        data_crc_err = 1'b0;
   logic        busy, done, st_nomatch, st_missing, st_crc_id, st_crc_data;
   logic [1:0]  st_code;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   trk_read_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_byte(cmd_byte),
      .cmd_id(cmd_id), .cmd_eot(cmd_eot), .index_pulse(index_pulse),
      .id_found(id_found), .id_value(id_value), .id_crc_err(id_crc_err),
      .data_done(data_done), .data_crc_err(data_crc_err), .busy(busy),
      .done(done), .st_code(st_code), .st_nomatch(st_nomatch),
      .st_missing(st_missing), .st_crc_id(st_crc_id), .st_crc_data(st_crc_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 idle, 1 wait index, 2 wait id, 3 data, 4 done
   int m_st = 0, m_idx = 0, m_sec = 0, m_eot = 1, m_code = 0;
   int m_nd = 0, m_ma = 0, m_ci = 0, m_cd = 0;
   logic [31:0] m_id = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_sec = 0; m_code = 0;
         m_nd = 0; m_ma = 0; m_ci = 0; m_cd = 0;
      end else begin
         case (m_st)
            0: if (cmd_start) begin
               m_nd = 0; m_ma = 0; m_ci = 0; m_cd = 0;
               m_id = cmd_id; m_sec = 0; m_idx = 0;
               m_eot = (cmd_eot == 0) ? 1 : int'(cmd_eot);
               if (cmd_byte[7] || cmd_byte[5]) begin m_code = 1; m_st = 4; end
               else begin m_code = 0; m_st = 1; end
            end
            1: if (index_pulse) begin m_idx = 1; m_st = 2; end
            2: if (id_found) begin
               m_idx = 0;
               if (id_value != m_id) m_nd = 1;
               if (id_crc_err) m_ci = 1;
               m_st = 3;
            end else if (index_pulse) begin
               m_idx++;
               if (m_idx >= 2) begin m_ma = 1; m_code = 1; m_st = 4; end
            end
            3: if (data_done) begin
               if (data_crc_err) m_cd = 1;
               m_sec++;
               m_st = (m_sec >= m_eot) ? 4 : 2;
            end
            default: m_st = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == (m_st >= 1 && m_st <= 3), "R2 busy", busy, m_st);
         chk(done == (m_st == 4), "R9 done", done, m_st == 4);
         chk(st_code == m_code[1:0], "R7 st_code", st_code, m_code);
         chk(st_nomatch == m_nd[0], "R5 st_nomatch", st_nomatch, m_nd);
         chk(st_missing == m_ma[0], "R8 st_missing", st_missing, m_ma);
         chk(st_crc_id == m_ci[0] && st_crc_data == m_cd[0], "R6 crc flags",
             {st_crc_id, st_crc_data}, m_ci * 2 + m_cd);
      end
   end

   task automatic go(input logic [7:0] b, input logic [31:0] id, input logic [7:0] eot);
      @(negedge clk);
      cmd_start = 1'b1; cmd_byte = b; cmd_id = id; cmd_eot = eot;
      @(negedge clk);
      cmd_start = 1'b0; cmd_id = 32'hFFFF_FFFF; cmd_eot = 8'd0;
   endtask

   task automatic idx();
      @(negedge clk); index_pulse = 1'b1;
      @(negedge clk); index_pulse = 1'b0;
   endtask

   task automatic sector(input logic [31:0] id, input bit icrc, input bit dcrc);
      @(negedge clk); id_found = 1'b1; id_value = id; id_crc_err = icrc;
      @(negedge clk); id_found = 1'b0; id_crc_err = 1'b0;
      @(negedge clk); data_done = 1'b1; data_crc_err = dcrc;
      @(negedge clk); data_done = 1'b0; data_crc_err = 1'b0;
   endtask

   task automatic wait_done(input string req, output int cycles);
      cycles = 0;
      while (!done && cycles < 50) begin
         @(negedge clk);
         cycles++;
      end
      chk(done == 1'b1, req, done, 1);
   endtask

   localparam logic [31:0] ID_A = 32'h0102_0304;

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
      chk(st_code == 0 && !st_nomatch && !st_missing && !st_crc_id && !st_crc_data,
          "R1 status", {st_code, st_nomatch, st_missing, st_crc_id, st_crc_data}, 0);
      rst_n = 1'b1;

      // R4/R7 normal three-sector read, R field in arbitrary order
      go(8'h00, ID_A, 8'd3);
      idx();
      sector(ID_A, 0, 0);
      chk(busy == 1, "R4 still busy after one sector", busy, 1);
      sector(ID_A, 0, 0);
      sector(ID_A, 0, 0);
      wait_done("R7 done after eot", cyc);
      chk(st_code == 0 && !st_nomatch, "R7 normal code", st_code, 0);
      @(negedge clk);
      chk(!busy && !done, "R9 idle after done", {busy, done}, 0);
      chk(st_code == 0, "R9 code holds", st_code, 0);

      // R5/R6 mismatch and CRC errors do not stop the read
      go(8'h00, ID_A, 8'd2);
      idx();
      sector(32'h0102_0904, 1, 0);
      chk(busy == 1 && st_nomatch && st_crc_id, "R6 read continues", busy, 1);
      sector(ID_A, 0, 1);
      wait_done("R6 done", cyc);
      chk(st_nomatch == 1, "R5 nomatch", st_nomatch, 1);
      chk(st_crc_id && st_crc_data, "R6 crc flags", {st_crc_id, st_crc_data}, 3);
      chk(st_code == 0, "R7 code normal with crc", st_code, 0);

      // R10 new command clears flags; R3 refused multi-track
      go(8'h80, ID_A, 8'd1);
      chk(done == 1, "R3 done one cycle after start", done, 1);
      chk(st_code == 1, "R3 code abnormal", st_code, 1);
      chk(!st_nomatch && !st_crc_id && !st_crc_data && !st_missing, "R10 flags cleared",
          {st_nomatch, st_crc_id, st_crc_data, st_missing}, 0);
      @(negedge clk);
      // R3 refused skip
      go(8'h20, ID_A, 8'd1);
      chk(done == 1 && st_code == 1, "R3 skip refused", st_code, 1);
      @(negedge clk);

      // R8 missing mark after starting index
      go(8'h46, ID_A, 8'd2);
      idx();
      repeat (3) @(negedge clk);
      chk(busy == 1, "R8 one index is not enough", busy, 1);
      idx();
      wait_done("R8 abort", cyc);
      chk(st_missing && st_code == 1, "R8 missing flag", {st_missing, st_code}, 5);

      // R8 counter restarts at each ID
      go(8'h00, ID_A, 8'd3);
      idx();
      sector(ID_A, 0, 0);
      idx();
      sector(ID_A, 0, 0);
      chk(busy == 1 && !st_missing, "R8 index count cleared by ID", st_missing, 0);
      idx();
      idx();
      wait_done("R8 abort mid-track", cyc);
      chk(st_missing == 1 && st_code == 1, "R8 abort code", st_code, 1);

      // R2 strobes before index ignored
      go(8'h00, ID_A, 8'd1);
      sector(32'hDEAD_BEEF, 1, 1);
      chk(busy && !st_nomatch && !st_crc_id, "R2 early strobes ignored", st_nomatch, 0);
      idx();
      sector(ID_A, 0, 0);
      wait_done("R2 done", cyc);
      chk(!st_nomatch && !st_crc_data, "R2 flags clean", {st_nomatch, st_crc_data}, 0);

      // R11 start while busy, stray data strobe, index during data
      go(8'h00, ID_A, 8'd2);
      idx();
      go(8'hA0, ID_A, 8'd1);
      chk(busy == 1 && st_code == 0, "R11 start ignored", st_code, 0);
      @(negedge clk); data_done = 1'b1;
      @(negedge clk); data_done = 1'b0;
      @(negedge clk); id_found = 1'b1; id_value = ID_A;
      @(negedge clk); id_found = 1'b0;
      idx();
      idx();
      @(negedge clk); data_done = 1'b1;
      @(negedge clk); data_done = 1'b0;
      chk(busy == 1 && !st_missing, "R11 stray strobes ignored", busy, 1);
      sector(ID_A, 0, 0);
      wait_done("R11 done after two sectors", cyc);
      chk(st_code == 0, "R11 normal code", st_code, 0);

      // R7 eot of zero acts as one
      go(8'h00, ID_A, 8'd0);
      idx();
      sector(ID_A, 0, 0);
      @(negedge clk);
      chk(done == 1 || !busy, "R7 eot zero ends after one", busy, 0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule